// File: doc/BRIEF.md
# Strided Bit-Vector Match Element

This block is one cell of a two-dimensional systolic packet classifier. It looks at one s-bit stride of a header field on behalf of a cluster of n rules. It produces an n-bit local match vector, where bit i is set when rule i accepts the stride value. The local vector is ANDed with the partial match vector that arrives from the neighbour on the left, and the product is registered toward the neighbour on the right. The stride itself is registered and passed on to the neighbour below. Each direction therefore costs exactly one cycle.

A single storage block of max(2^s, 2n) entries, each max(n, s) bits wide, serves two matching modes. In prefix mode the stride value addresses the block directly, and the entry read is the rule vector. In range mode, entry 2i holds the lower bound of rule i and entry 2i+1 holds its upper bound. The stride is tested against every pair at the same time. A mode input picks the interpretation for each lookup. A plain write port fills the storage.

Top module: `strided_bv_pe`

## Requirements
- R1: While reset is low and after it is released, hdrOutValid, vecOutValid and vecOut are 0 and every storage entry is zero. A prefix lookup straight after reset therefore yields an all-zero vector.
- R2: One cycle after a cycle with hdrInValid=1, hdrOutValid is 1 and hdrOut equals that cycle's hdrIn. One cycle after hdrInValid=0, hdrOutValid is 0.
- R3: With modeRange=0, one cycle after a cycle with both valids high, vecOut equals vecIn AND the storage entry addressed by hdrIn, taking the low n bits of that entry.
- R4: With modeRange=1, the local bit i is 1 exactly when lo_i <= hdrIn <= hi_i. lo_i is the low s bits of entry 2i and hi_i is the low s bits of entry 2i+1. Higher entry bits are ignored. The result is ANDed with vecIn and appears one cycle later.
- R5: vecOutValid is 1 one cycle after a cycle in which hdrInValid and vecInValid are both 1, and 0 otherwise. vecOut is all-zero whenever vecOutValid is 0.
- R6: A write presented with wrEn=1 changes entry wrAddr at the next clock edge. A lookup in the same cycle as the write sees the old content, and a lookup in the following cycle sees the new content.
- R7: Range bounds are inclusive at both ends. A rule whose lower bound exceeds its upper bound never matches.
- R8: The mode input acts per lookup. The same stored content is read as a bit-vector table on a cycle with modeRange=0 and as bound pairs on a cycle with modeRange=1, with no rewrite in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeRange | input | 1 | 0 = prefix table lookup, 1 = range compare |
| wrEn | input | 1 | Storage write strobe |
| wrAddr | input | 4 | Storage entry index (log2 of depth) |
| wrData | input | 8 | Entry contents (max(n, s) bits) |
| hdrInValid | input | 1 | Stride from above is valid |
| hdrIn | input | 4 | Header stride from above (s bits) |
| vecInValid | input | 1 | Vector from the left is valid |
| vecIn | input | 8 | Partial match vector from the left (n bits) |
| hdrOutValid | output | 1 | Stride to below is valid |
| hdrOut | output | 4 | Registered header stride to below |
| vecOutValid | output | 1 | Vector to the right is valid |
| vecOut | output | 8 | Registered AND of vecIn and the local match |

## Verification
The hardest case to reach is a write that lands on the very entry a lookup reads in the same cycle. Only a bench that drives both on one cycle can tell old content from new. The stimulus presents such a collision and then repeats the lookup on the next cycle. A second hard case is reading one storage image under both modes. To reach it, the bench flips modeRange between back-to-back lookups on unchanged content, so every entry is seen both as a vector and as a bound. Range bounds are loaded with nonzero upper bits, an inverted pair and single-point pairs. This exercises the inclusive edges and the empty rule.

// File: rtl/sbv_pkg.sv
package sbv_pkg;

  // Strobes from control to datapath, one cycle's worth.
  typedef struct packed {
    logic memWr;     // commit wrData into storage at this edge
    logic hdrTake;   // header stride presented this cycle is valid
    logic vecTake;   // both directions valid: produce a vector
    logic rangeSel;  // interpret storage as bound pairs
  } sbv_strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbv_ctrl.sv
module sbv_ctrl
  import sbv_pkg::*;
(
  input  logic        wrEn,
  input  logic        modeRange,
  input  logic        hdrInValid,
  input  logic        vecInValid,
  output sbv_strobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.memWr    = wrEn;
    strobe.hdrTake  = hdrInValid;
    strobe.vecTake  = hdrInValid & vecInValid;
    strobe.rangeSel = modeRange;
  end

endmodule

// File: rtl/sbv_datapath.sv
module sbv_datapath
  import sbv_pkg::*;
#(
  parameter int STRIDE_W = 4,
  parameter int RULES    = 8,
  localparam int DEPTH   = maxOf(1 << STRIDE_W, 2 * RULES),
  localparam int WIDTH   = maxOf(RULES, STRIDE_W),
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbv_strobe_t         strobe,
  input  logic [AW-1:0]       wrAddr,
  input  logic [WIDTH-1:0]    wrData,
  input  logic [STRIDE_W-1:0] hdrIn,
  input  logic [RULES-1:0]    vecIn,
  output logic                hdrOutValid,
  output logic [STRIDE_W-1:0] hdrOut,
  output logic                vecOutValid,
  output logic [RULES-1:0]    vecOut
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    hdrIdx;
  logic [RULES-1:0] prefixVec;
  logic [RULES-1:0] rangeVec;
  logic [RULES-1:0] localVec;

  // Shared storage: bit-vector table or bound pairs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) store[e] <= '0;
    end else if (strobe.memWr) begin
      store[wrAddr] <= wrData;
    end
  end

  assign hdrIdx    = AW'(hdrIn);
  assign prefixVec = store[hdrIdx][RULES-1:0];

  // One comparator pair per rule; entry 2i is low bound, 2i+1 high bound.
  for (genvar g = 0; g < RULES; g++) begin : g_rule
    logic [STRIDE_W-1:0] loBound;
    logic [STRIDE_W-1:0] hiBound;
    assign loBound     = store[2*g][STRIDE_W-1:0];
    assign hiBound     = store[2*g+1][STRIDE_W-1:0];
    assign rangeVec[g] = (loBound <= hdrIn) && (hdrIn <= hiBound);
  end

  assign localVec = strobe.rangeSel ? rangeVec : prefixVec;

  // Vertical stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrOutValid <= 1'b0;
      hdrOut      <= '0;
    end else begin
      hdrOutValid <= strobe.hdrTake;
      hdrOut      <= hdrIn;
    end
  end

  // Horizontal stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecOutValid <= 1'b0;
      vecOut      <= '0;
    end else begin
      vecOutValid <= strobe.vecTake;
      vecOut      <= strobe.vecTake ? (vecIn & localVec) : '0;
    end
  end

endmodule

// File: rtl/strided_bv_pe.sv
module strided_bv_pe
  import sbv_pkg::*;
#(
  parameter int STRIDE_W = 4,
  parameter int RULES    = 8,
  localparam int DEPTH   = maxOf(1 << STRIDE_W, 2 * RULES),
  localparam int WIDTH   = maxOf(RULES, STRIDE_W),
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeRange,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [WIDTH-1:0]    wrData,
  input  logic                hdrInValid,
  input  logic [STRIDE_W-1:0] hdrIn,
  input  logic                vecInValid,
  input  logic [RULES-1:0]    vecIn,
  output logic                hdrOutValid,
  output logic [STRIDE_W-1:0] hdrOut,
  output logic                vecOutValid,
  output logic [RULES-1:0]    vecOut
);

  sbv_strobe_t strobe;

  sbv_ctrl u_ctrl (
    .wrEn       (wrEn),
    .modeRange  (modeRange),
    .hdrInValid (hdrInValid),
    .vecInValid (vecInValid),
    .strobe     (strobe)
  );

  sbv_datapath #(
    .STRIDE_W (STRIDE_W),
    .RULES    (RULES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .hdrIn       (hdrIn),
    .vecIn       (vecIn),
    .hdrOutValid (hdrOutValid),
    .hdrOut      (hdrOut),
    .vecOutValid (vecOutValid),
    .vecOut      (vecOut)
  );

endmodule

// File: rtl/strided_bv_pe_chk.sv
module strided_bv_pe_chk #(
  parameter int STRIDE_W = 4,
  parameter int RULES    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                hdrInValid,
  input logic [STRIDE_W-1:0] hdrIn,
  input logic                vecInValid,
  input logic [RULES-1:0]    vecIn,
  input logic                hdrOutValid,
  input logic [STRIDE_W-1:0] hdrOut,
  input logic                vecOutValid,
  input logic [RULES-1:0]    vecOut
);

  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (!hdrOutValid && !vecOutValid && vecOut == '0);
    end
  end

  p_hdr_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    hdrInValid |=> (hdrOutValid && hdrOut == $past(hdrIn)));

  p_hdr_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !hdrInValid |=> !hdrOutValid);

  p_vec_subset_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hdrInValid && vecInValid) |=> ((vecOut & ~$past(vecIn)) == '0));

  p_vec_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrInValid && vecInValid) |=> vecOutValid);

  p_vec_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrInValid && vecInValid) |=> !vecOutValid);

  p_vec_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !vecOutValid |-> vecOut == '0);

endmodule

bind strided_bv_pe strided_bv_pe_chk #(
  .STRIDE_W (STRIDE_W),
  .RULES    (RULES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hdrInValid  (hdrInValid),
  .hdrIn       (hdrIn),
  .vecInValid  (vecInValid),
  .vecIn       (vecIn),
  .hdrOutValid (hdrOutValid),
  .hdrOut      (hdrOut),
  .vecOutValid (vecOutValid),
  .vecOut      (vecOut)
);

// File: tb/strided_bv_pe_bench.sv
module strided_bv_pe_bench;

  localparam int S = 4;
  localparam int N = 8;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         modeRange = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic         hdrInValid = 1'b0;
  logic [S-1:0] hdrIn = '0;
  logic         vecInValid = 1'b0;
  logic [N-1:0] vecIn = '0;
  logic         hdrOutValid;
  logic [S-1:0] hdrOut;
  logic         vecOutValid;
  logic [N-1:0] vecOut;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic [7:0] model [D];

  always #5 clk = ~clk;

  strided_bv_pe u_strided_bv_pe (
    .clk(clk), .rstN(rstN), .modeRange(modeRange), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .hdrInValid(hdrInValid),
    .hdrIn(hdrIn), .vecInValid(vecInValid), .vecIn(vecIn),
    .hdrOutValid(hdrOutValid), .hdrOut(hdrOut),
    .vecOutValid(vecOutValid), .vecOut(vecOut)
  );

  // Stimulus table: {mode, hdrValid, vecValid, hdr[3:0], vec[7:0]}
  localparam int NTAB = 14;
  localparam logic [14:0] TAB [NTAB] = '{
    {1'b0, 1'b1, 1'b1, 4'h0, 8'hFF},
    {1'b0, 1'b1, 1'b1, 4'h1, 8'hFF},
    {1'b0, 1'b1, 1'b1, 4'h7, 8'hF0},
    {1'b0, 1'b1, 1'b1, 4'hA, 8'h0F},
    {1'b0, 1'b1, 1'b1, 4'hF, 8'hFF},
    {1'b0, 1'b1, 1'b1, 4'h5, 8'hA5},
    {1'b0, 1'b1, 1'b0, 4'h3, 8'hFF},
    {1'b0, 1'b0, 1'b1, 4'h3, 8'hFF},
    {1'b1, 1'b1, 1'b1, 4'h4, 8'hFF},
    {1'b0, 1'b1, 1'b1, 4'h4, 8'hFF},
    {1'b1, 1'b1, 1'b1, 4'hC, 8'hFF},
    {1'b0, 1'b1, 1'b1, 4'hC, 8'hFF},
    {1'b1, 1'b1, 1'b1, 4'h9, 8'h3C},
    {1'b0, 1'b0, 1'b0, 4'h9, 8'hFF}
  };

  function automatic logic [N-1:0] refMatch(input logic m, input logic [S-1:0] h);
    logic [N-1:0] r;
    if (!m) return model[h];
    for (int i = 0; i < N; i++)
      r[i] = (model[2*i][S-1:0] <= h) && (h <= model[2*i+1][S-1:0]);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, optional write, check after the edge.
  task automatic step(input logic m, input logic hv, input logic vv,
                      input logic [S-1:0] h, input logic [N-1:0] v,
                      input logic we, input logic [3:0] wa, input logic [7:0] wd,
                      input string tag);
    logic [N-1:0] expVec;
    logic         expVV;
    @(negedge clk);
    modeRange = m; hdrInValid = hv; vecInValid = vv; hdrIn = h; vecIn = v;
    wrEn = we; wrAddr = wa; wrData = wd;
    expVV  = hv && vv;
    expVec = expVV ? (refMatch(m, h) & v) : '0;
    @(posedge clk);
    if (we) model[wa] = wd;
    @(negedge clk);
    wrEn = 1'b0; hdrInValid = 1'b0; vecInValid = 1'b0;
    check(vecOut == expVec, {tag, " vecOut"}, vecOut, expVec);
    check(vecOutValid == expVV, {tag, " vecOutValid R5"}, vecOutValid, expVV);
    check(hdrOutValid == hv, {tag, " hdrOutValid R2"}, hdrOutValid, hv);
    if (hv) check(hdrOut == h, {tag, " hdrOut R2"}, hdrOut, h);
    #0;
  endtask

  task automatic writeEntry(input logic [3:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, a, d, "write");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    for (int e = 0; e < D; e++) model[e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!hdrOutValid && !vecOutValid && vecOut == '0, "R1 outputs in reset",
          {hdrOutValid, vecOutValid, vecOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!vecOutValid && vecOut == '0, "R1 after release", vecOut, 0);
    // R1: storage cleared, prefix lookup gives zero
    step(1'b0, 1'b1, 1'b1, 4'h9, 8'hFF, 1'b0, '0, '0, "R1 cleared table");

    // Prefix table content for R3 and R8
    for (int v = 0; v < D; v++) writeEntry(4'(v), 8'((v * 29) ^ 8'h5A));
    for (int k = 0; k < NTAB; k++)
      step(TAB[k][14], TAB[k][13], TAB[k][12], TAB[k][11:8], TAB[k][7:0],
           1'b0, '0, '0, TAB[k][14] ? "R8 R4 table range" : "R3 table prefix");

    // Range bounds for R4 and R7 (upper nibble filled with junk)
    writeEntry(4'd0,  8'hA0); writeEntry(4'd1,  8'h5F);  // rule0: 0..15
    writeEntry(4'd2,  8'hC3); writeEntry(4'd3,  8'h37);  // rule1: 3..7
    writeEntry(4'd4,  8'h07); writeEntry(4'd5,  8'hF7);  // rule2: 7..7
    writeEntry(4'd6,  8'h19); writeEntry(4'd7,  8'h24);  // rule3: empty 9..4
    writeEntry(4'd8,  8'h60); writeEntry(4'd9,  8'h90);  // rule4: 0..0
    writeEntry(4'd10, 8'h0F); writeEntry(4'd11, 8'hEF);  // rule5: 15..15
    writeEntry(4'd12, 8'h55); writeEntry(4'd13, 8'h3A);  // rule6: 5..10
    writeEntry(4'd14, 8'h8C); writeEntry(4'd15, 8'h7E);  // rule7: 12..14
    step(1'b1, 1'b1, 1'b1, 4'h0, 8'hFF, 1'b0, '0, '0, "R7 low edge");
    step(1'b1, 1'b1, 1'b1, 4'h3, 8'hFF, 1'b0, '0, '0, "R7 lower bound");
    step(1'b1, 1'b1, 1'b1, 4'h7, 8'hFF, 1'b0, '0, '0, "R7 upper bound");
    step(1'b1, 1'b1, 1'b1, 4'h8, 8'hFF, 1'b0, '0, '0, "R4 middle");
    step(1'b1, 1'b1, 1'b1, 4'hA, 8'hFF, 1'b0, '0, '0, "R4 rule6 top");
    step(1'b1, 1'b1, 1'b1, 4'hE, 8'h7F, 1'b0, '0, '0, "R4 masked rule7");
    step(1'b1, 1'b1, 1'b1, 4'hF, 8'hFF, 1'b0, '0, '0, "R7 high edge");
    step(1'b1, 1'b1, 1'b1, 4'h5, 8'h08, 1'b0, '0, '0, "R7 empty rule3");
    step(1'b0, 1'b1, 1'b1, 4'h5, 8'hFF, 1'b0, '0, '0, "R8 same image prefix");
    step(1'b1, 1'b1, 1'b0, 4'h5, 8'hFF, 1'b0, '0, '0, "R5 vec not valid");

    // R6: write and lookup of the same entry in one cycle, then next cycle
    step(1'b0, 1'b1, 1'b1, 4'h3, 8'hFF, 1'b1, 4'h3, 8'hC6, "R6 same cycle old");
    step(1'b0, 1'b1, 1'b1, 4'h3, 8'hFF, 1'b0, '0, '0, "R6 next cycle new");
    check(model[3] == 8'hC6, "R6 model updated", model[3], 8'hC6);

    done = 1'b1;
    summary();
  end

endmodule